// File: doc/BRIEF.md
# BCD Accumulator Correction Unit

This unit repairs an 8-bit accumulator after a binary add or subtract of two packed BCD operands, so that the value again holds two valid decimal digits. It takes the raw accumulator together with the half-carry, subtract and carry flags left by the preceding arithmetic step. It returns the corrected accumulator and a fresh set of sign, zero, parity, half-carry and carry flags.

A single correction constant is built from the two nibbles and the incoming flags. That constant is added to the accumulator when the subtract flag is clear and subtracted when it is set, with all arithmetic wrapping modulo 256. The corrected value and the flags are captured in output registers on the clock edge where the enable strobe is high. At every other edge the registers keep their values. The subtract flag is an input only and is never altered.

Top module: `bcd_adjust_unit`

## Requirements
- R1: After reset the outputs read accumulator 0x00, sign 0, zero 1, parity 1, half 0 and carry 0.
- R2: The correction includes 0x06 when the low nibble of the accumulator is 0xA or above, or when the half-carry input is 1; otherwise its low nibble is 0.
- R3: The high-digit limit is 0x90 when the low nibble is 0xA or above and 0xA0 otherwise. An accumulator at or above that limit adds 0x60 to the correction and sets carry to 1.
- R4: A carry input of 1 always adds 0x60 to the correction and yields carry 1. The unit never drives carry to 0 unless carry input and limit test are both 0.
- R5: With the subtract input at 1 the correction is subtracted from the accumulator; with it at 0 the correction is added. Both wrap modulo 256.
- R6: Sign equals bit 7 of the new accumulator, zero is 1 exactly when the new accumulator is 0x00, and parity is 1 when the new accumulator has an even number of 1 bits.
- R7: Half-carry out equals bit 4 of (incoming accumulator XOR corrected accumulator).
- R8: Results appear on the outputs one clock edge after the enable is sampled high, and outputs hold their values at every edge where enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture strobe for one correction |
| acc_in | input | 8 | Accumulator after the binary operation |
| half_in | input | 1 | Half-carry flag from the binary operation |
| sub_in | input | 1 | 1 when the binary operation was a subtraction |
| carry_in | input | 1 | Carry flag from the binary operation |
| acc_q | output | 8 | Corrected accumulator |
| sign_q | output | 1 | Sign of the corrected accumulator |
| zero_q | output | 1 | Corrected accumulator equals zero |
| parity_q | output | 1 | Even parity of the corrected accumulator |
| half_q | output | 1 | New half-carry flag |
| carry_q | output | 1 | New carry flag |

## Verification
The assertions assume that the data and flag inputs are known and steady around every edge where enable is high. They assume nothing about whether those inputs form a legal BCD result. That means a carry input of 1 together with a small accumulator, or half-carry with a large low nibble, must still follow the rules. The stimulus changes inputs only just after a rising edge and sweeps all 256 accumulator values against every combination of the three flags. It also inserts idle cycles with scrambled inputs so that the hold behaviour is exercised.

// File: rtl/bcd_adjust_pkg.sv
package bcd_adjust_pkg;
  localparam int DIGIT_W  = 4;
  localparam int WORD_W   = 2 * DIGIT_W;
  localparam int DIGIT_MAX = 9;

  localparam logic [WORD_W-1:0] LOW_FIX   = WORD_W'(DIGIT_MAX + 1 - 4);
  localparam logic [WORD_W-1:0] HIGH_FIX  = WORD_W'(LOW_FIX << DIGIT_W);
  localparam logic [WORD_W-1:0] LIMIT_LOW = WORD_W'(DIGIT_MAX << DIGIT_W);
  localparam logic [WORD_W-1:0] LIMIT_HI  = WORD_W'((DIGIT_MAX + 1) << DIGIT_W);

  typedef struct packed {
    logic sign;
    logic zero;
    logic parity;
    logic half;
    logic carry;
  } adj_flags_t;

  localparam adj_flags_t FLAGS_RESET = '{sign: 1'b0, zero: 1'b1, parity: 1'b1,
                                         half: 1'b0, carry: 1'b0};
endpackage

// File: rtl/bcd_adjust_corr.sv
module bcd_adjust_corr
  import bcd_adjust_pkg::*;
(
  input  logic [WORD_W-1:0] acc,
  input  logic              half,
  input  logic              carry,
  output logic [WORD_W-1:0] corr,
  output logic              carry_next
);
  logic              low_over;
  logic [WORD_W-1:0] limit;
  logic              high_fix;

  always_comb begin
    low_over   = acc[DIGIT_W-1:0] > DIGIT_W'(DIGIT_MAX);
    limit      = low_over ? LIMIT_LOW : LIMIT_HI;
    high_fix   = carry | (acc >= limit);
    corr       = '0;
    if (low_over | half) corr = corr | LOW_FIX;
    if (high_fix)        corr = corr | HIGH_FIX;
    carry_next = high_fix;
  end
endmodule

// File: rtl/bcd_adjust_apply.sv
module bcd_adjust_apply
  import bcd_adjust_pkg::*;
(
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] corr,
  input  logic              sub,
  output logic [WORD_W-1:0] result,
  output logic              sign,
  output logic              zero,
  output logic              parity,
  output logic              half
);
  logic [WORD_W-1:0] diff_bits;
  logic [WORD_W:0]   par_chain;

  always_comb begin
    if (sub) result = acc - corr;
    else     result = acc + corr;
    diff_bits = acc ^ result;
    sign      = result[WORD_W-1];
    zero      = (result == '0);
    half      = diff_bits[DIGIT_W];
  end

  assign par_chain[0] = 1'b1;
  genvar gi;
  generate
    for (gi = 0; gi < WORD_W; gi++) begin : g_par
      assign par_chain[gi+1] = par_chain[gi] ^ result[gi];
    end
  endgenerate
  assign parity = par_chain[WORD_W];
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adjust_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              half_in,
  input  logic              sub_in,
  input  logic              carry_in,
  output logic [WORD_W-1:0] acc_q,
  output logic              sign_q,
  output logic              zero_q,
  output logic              parity_q,
  output logic              half_q,
  output logic              carry_q
);
  logic [WORD_W-1:0] corr;
  logic              carry_calc;
  logic [WORD_W-1:0] result;
  adj_flags_t        flags_calc;
  adj_flags_t        flags_r, flags_d;
  logic [WORD_W-1:0] acc_r, acc_d;

  bcd_adjust_corr u_corr (
    .acc        (acc_in),
    .half       (half_in),
    .carry      (carry_in),
    .corr       (corr),
    .carry_next (carry_calc)
  );

  bcd_adjust_apply u_apply (
    .acc    (acc_in),
    .corr   (corr),
    .sub    (sub_in),
    .result (result),
    .sign   (flags_calc.sign),
    .zero   (flags_calc.zero),
    .parity (flags_calc.parity),
    .half   (flags_calc.half)
  );
  assign flags_calc.carry = carry_calc;

  always_comb begin
    acc_d   = acc_r;
    flags_d = flags_r;
    if (en) begin
      acc_d   = result;
      flags_d = flags_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r   <= '0;
      flags_r <= FLAGS_RESET;
    end else begin
      acc_r   <= acc_d;
      flags_r <= flags_d;
    end
  end

  assign acc_q    = acc_r;
  assign sign_q   = flags_r.sign;
  assign zero_q   = flags_r.zero;
  assign parity_q = flags_r.parity;
  assign half_q   = flags_r.half;
  assign carry_q  = flags_r.carry;
endmodule

// File: rtl/bcd_adjust_unit_chk.sv
module bcd_adjust_unit_chk
  import bcd_adjust_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [WORD_W-1:0] acc_in,
  input logic              half_in,
  input logic              sub_in,
  input logic              carry_in,
  input logic [WORD_W-1:0] acc_q,
  input logic              sign_q,
  input logic              zero_q,
  input logic              parity_q,
  input logic              half_q,
  input logic              carry_q
);
  AST_CARRY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && carry_in) |=> carry_q); // R4

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q == (acc_q == '0)); // R6

  AST_SIGN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sign_q == acc_q[WORD_W-1]); // R6

  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    parity_q == ~(^acc_q)); // R6

  AST_HALF_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (half_q == (($past(acc_in) ^ acc_q) >> DIGIT_W) % 2)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_q) && $stable(carry_q) && $stable(half_q))); // R8

  AST_ADD_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sub_in && !half_in && !carry_in && acc_in[DIGIT_W-1:0] <= DIGIT_W'(DIGIT_MAX)
        && acc_in < LIMIT_HI) |=> (acc_q == $past(acc_in) && !carry_q)); // R3
endmodule

bind bcd_adjust_unit bcd_adjust_unit_chk u_chk (.*);

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] acc;
    logic       s, z, p, h, c;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] acc_in = '0;
  logic       half_in = 1'b0, sub_in = 1'b0, carry_in = 1'b0;
  logic [7:0] acc_q;
  logic       sign_q, zero_q, parity_q, half_q, carry_q;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  exp_t last;
  logic armed = 1'b0;
  logic monitor_on = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adjust_unit dut (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_in(acc_in),
    .half_in(half_in), .sub_in(sub_in), .carry_in(carry_in),
    .acc_q(acc_q), .sign_q(sign_q), .zero_q(zero_q),
    .parity_q(parity_q), .half_q(half_q), .carry_q(carry_q)
  );

  function automatic exp_t model(input logic [7:0] a, input logic h, input logic n,
                                 input logic c, input string req);
    exp_t e;
    logic [7:0] k;
    logic [7:0] lim;
    logic big_lo;
    logic hi;
    big_lo = (a[3:0] >= 4'hA);
    lim    = big_lo ? 8'h90 : 8'hA0;
    hi     = c || (a >= lim);
    k      = 8'h00;
    if (big_lo || h) k = k + 8'h06;
    if (hi)          k = k + 8'h60;
    e.acc = n ? 8'(a - k) : 8'(a + k);
    e.s   = e.acc[7];
    e.z   = (e.acc == 8'h00);
    e.p   = ($countones(e.acc) % 2) == 0;
    e.h   = ((a ^ e.acc) & 8'h10) != 0;
    e.c   = hi;
    e.req = req;
    return e;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    checks++;
    if (acc_q !== e.acc || sign_q !== e.s || zero_q !== e.z ||
        parity_q !== e.p || half_q !== e.h || carry_q !== e.c) begin
      errors++;
      $display("FAIL %s %s: got acc=%h s%b z%b p%b h%b c%b, expected acc=%h s%b z%b p%b h%b c%b",
               e.req, tag, acc_q, sign_q, zero_q, parity_q, half_q, carry_q,
               e.acc, e.s, e.z, e.p, e.h, e.c);
    end
  endtask

  // driver: inputs change just after a rising edge
  task automatic drive(input logic [7:0] a, input logic h, input logic n,
                       input logic c, input exp_t e);
    @(posedge clk); #1;
    acc_in = a; half_in = h; sub_in = n; carry_in = c; en = 1'b1;
    q.push_back(e);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      en = 1'b0;
      acc_in = 8'(acc_in * 8'd37 + 8'd11);
      half_in = ~half_in; sub_in = ~sub_in; carry_in = ~carry_in;
    end
  endtask

  function automatic exp_t mk(input logic [7:0] a, input logic s, input logic z,
                              input logic p, input logic h, input logic c, input string r);
    exp_t e;
    e.acc = a; e.s = s; e.z = z; e.p = p; e.h = h; e.c = c; e.req = r;
    return e;
  endfunction

  // monitor: compares away from the rising edge
  initial begin
    last = mk(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
    forever begin
      @(negedge clk);
      if (monitor_on) begin
        if (armed) begin
          if (q.size() > 0) begin
            last = q.pop_front();
            compare(last, "result");
          end else begin
            checks++; errors++;
            $display("FAIL R8: result seen with empty queue, got acc=%h expected none", acc_q);
          end
        end else begin
          compare(mk(last.acc, last.s, last.z, last.p, last.h, last.c, "R8"), "hold");
        end
        armed = en;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    compare(mk(8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R1"), "reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    monitor_on = 1'b1;
    idle(2);
    // hand-computed directed cases
    drive(8'h3C, 0, 0, 0, mk(8'h42, 0, 0, 1, 1, 0, "R2"));
    drive(8'h9A, 0, 0, 0, mk(8'h00, 0, 1, 1, 1, 1, "R3"));
    drive(8'hA0, 0, 0, 0, mk(8'h00, 0, 1, 1, 0, 1, "R3"));
    drive(8'h9F, 0, 0, 0, mk(8'h05, 0, 0, 1, 1, 1, "R3"));
    drive(8'h99, 0, 0, 0, mk(8'h99, 1, 0, 1, 0, 0, "R6"));
    drive(8'h12, 0, 0, 1, mk(8'h72, 0, 0, 1, 0, 1, "R4"));
    drive(8'h2D, 1, 1, 0, mk(8'h27, 0, 0, 1, 0, 0, "R5"));
    drive(8'hF0, 0, 1, 1, mk(8'h90, 1, 0, 1, 0, 1, "R5"));
    drive(8'h11, 1, 0, 0, mk(8'h17, 0, 0, 1, 0, 0, "R2"));
    idle(4);
    // exhaustive sweep with hold gaps
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 256; a++) begin
        drive(8'(a), f[0], f[1], f[2],
              model(8'(a), f[0], f[1], f[2], f[1] ? "R5" : "R7"));
        if (a % 64 == 63) idle(2);
      end
    end
    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule